// File: doc/BRIEF.md
# Glitch-Free Clock Source Switcher

This block picks the system clock from three sources and changes between them without ever putting a shortened high or low phase on the output. The three sources are a primary clock, a slow low-power secondary clock and a fast internal RC clock divided down by a postscaler. A control domain clocked by the always-running internal RC clock holds the 2-bit source-select register and the 3-bit frequency-select register. It turns the select value, the configuration state and the secondary-enable flag into a target source, and it drives one request line per source.

Each source has its own branch. A branch synchronizes its request on the falling edge of its own clock and opens or closes an AND gate on that clock. A request is raised only after the control domain has seen every other gate closed. When the source changes, the old clock therefore stops after two of its own falling edges, and the new one starts after three of its own falling edges. While a change is in progress a busy flag is high. Select writes made during that time are kept and acted on once the change completes.

After reset the internal clock drives the output until the configuration-loaded flag rises. A divide-by-4 copy of the system clock is driven on a clock-output pin only when the primary mode is the RC mode.

Top module: `clksw_top`

## Requirements
- R1: On reset `src_sel` reads 2'b00, `freq_sel` reads 3'b110, `busy` is 1 and `clko_oe` is 0, and `sys_clk` produces no rising edge while `rst` is high.
- R2: While `cfg_done` is low, the internal clock drives `sys_clk` whatever `src_sel` holds.
- R3: Once `cfg_done` is high, the select value decodes as follows. 2'b00 picks the primary clock, except when `prim_mode` is 3'd4 (internal), in which case it picks the internal clock. 2'b01 picks the secondary clock. Both 2'b10 and 2'b11 pick the internal clock. Mode codes: 0 crystal, 1 external clock, 2 RC, 3 RC with the output pin released, 4 internal.
- R4: A write of 2'b01 while `sec_osc_en` is low is dropped. `src_sel`, `busy` and the output clock stay as they were.
- R5: During a change of source, the longest low phase of `sys_clk` is at most 2 old-source periods plus 4 new-source periods plus 6 control-clock periods.
- R6: Every high and every low phase of `sys_clk` lasts at least half a period of the fastest source, and no two source gates are ever open at once.
- R7: `busy` rises within two control cycles of a write that changes the resolved source. It falls once the new gate is seen open, and while it is low exactly one gate is open.
- R8: A select write made while `busy` is high is stored. Once the current change ends, the last stored value is acted on.
- R9: A write, or an alias, that resolves to the source already active raises no `busy` and creates no pause on `sys_clk`.
- R10: When `cfg_done` is high and `prim_mode` is 3'd2, `clko_oe` is 1 and `clko` runs at `sys_clk`/4. In every other case `clko_oe` is 0 and `clko` is held low.
- R11: The internal clock is the control clock divided by 2^(7-`freq_sel`). A new frequency select takes effect only while the internal source is neither open nor the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset |
| rc_clk | input | 1 | Internal RC clock, also the control-domain clock |
| pri_clk | input | 1 | Primary source clock |
| sec_clk | input | 1 | Secondary low-power source clock |
| cfg_done | input | 1 | Configuration has been loaded |
| prim_mode | input | 3 | Primary mode code |
| sec_osc_en | input | 1 | Secondary oscillator enabled |
| sel_wr | input | 1 | Write strobe for the source select |
| sel_wdata | input | 2 | Source select write value |
| fsel_wr | input | 1 | Write strobe for the frequency select |
| fsel_wdata | input | 3 | Frequency select write value |
| sys_clk | output | 1 | Gated system clock |
| clko | output | 1 | System clock divided by 4, or low when released |
| clko_oe | output | 1 | Clock-output pin driven |
| busy | output | 1 | Source change in progress |
| src_sel | output | 2 | Stored source select |
| freq_sel | output | 3 | Stored frequency select |

## Verification
The bench builds the block with its default parameters: a 3-bit frequency select, a two-stage turn-off, a three-stage turn-on and two-flop synchronizers. The control clock runs at 8 ns, the primary at 20 ns and the secondary at 60 ns, so the bench covers changes from fast to slow and from slow to fast. Selecting the undivided internal setting makes the internal source the fastest, which puts the runt threshold right at that source's own half period. Because the mode code is changed during the run, a single pass reaches the alias cases and the release of the output pin.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    PM_XTAL   = 3'd0,
    PM_EXTCLK = 3'd1,
    PM_RC     = 3'd2,
    PM_RCIO   = 3'd3,
    PM_INTRC  = 3'd4
  } pmode_e;

  function automatic logic [NSRC-1:0] src_onehot(input src_e s);
    logic [NSRC-1:0] r;
    r    = '0;
    r[s] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/clksw_postscale.sv
`timescale 1ns/1ps
module clksw_postscale #(
  parameter int FSEL_W = 3
) (
  input  logic              rc_clk,
  input  logic              rst,
  input  logic [FSEL_W-1:0] fsel,
  output logic              int_clk
);
  localparam int DIV_W = (1 << FSEL_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   taps;

  always_ff @(posedge rc_clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // taps[k] divides rc_clk by 2^(DIV_W-k); the top tap is rc_clk itself
  for (genvar j = 0; j < DIV_W; j++) begin : g_tap
    assign taps[j] = cnt_q[DIV_W-1-j];
  end
  assign taps[DIV_W] = rc_clk;

  assign int_clk = taps[fsel];
endmodule

// File: rtl/clksw_branch.sv
`timescale 1ns/1ps
module clksw_branch #(
  parameter int OFF_STAGES = 2,
  parameter int ON_STAGES  = 3,
  parameter int RST_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst,
  input  logic req,
  output logic gate,
  output logic gclk
);
  localparam int DEPTH = (ON_STAGES > OFF_STAGES) ? ON_STAGES : OFF_STAGES;

  logic [RST_STAGES-1:0] rsync_q;
  logic [DEPTH-1:0]      en_q;
  logic                  lrst;

  always_ff @(negedge src_clk) begin
    rsync_q <= {rsync_q[RST_STAGES-2:0], rst};
  end
  assign lrst = rsync_q[RST_STAGES-1];

  // enable chain on the falling edge so the gate moves only while the clock is low
  always_ff @(negedge src_clk) begin
    if (lrst) en_q <= '0;
    else      en_q <= {en_q[DEPTH-2:0], req};
  end

  // closes after OFF_STAGES falling edges, opens after ON_STAGES
  assign gate = en_q[OFF_STAGES-1] & en_q[ON_STAGES-1];
  assign gclk = src_clk & gate;
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int FSEL_W       = 3,
  parameter int FSEL_RST     = 6,
  parameter int GSYNC_STAGES = 2
) (
  input  logic              rc_clk,
  input  logic              rst,
  input  logic              cfg_done,
  input  logic [2:0]        prim_mode,
  input  logic              sec_osc_en,
  input  logic              sel_wr,
  input  logic [1:0]        sel_wdata,
  input  logic              fsel_wr,
  input  logic [FSEL_W-1:0] fsel_wdata,
  input  logic [NSRC-1:0]   gate_async,
  output logic [1:0]        src_sel,
  output logic [FSEL_W-1:0] freq_sel,
  output logic [FSEL_W-1:0] fsel_live,
  output logic [NSRC-1:0]   req,
  output logic              busy,
  output logic              clko_oe,
  output src_e              tgt
);
  logic [1:0]        sel_q;
  logic [FSEL_W-1:0] fsel_q, fsel_live_q;
  src_e              tgt_q, resolved;
  logic [NSRC-1:0]   req_q, req_d, toh, gseen;
  logic [NSRC-1:0]   gs_q [GSYNC_STAGES];
  logic              busy_q, oe_q, settled, sel_drop;

  assign gseen   = gs_q[GSYNC_STAGES-1];
  assign toh     = src_onehot(tgt_q);
  assign settled = (gseen == toh);
  assign sel_drop = (sel_wdata == 2'b01) && !sec_osc_en;

  always_comb begin
    resolved = tgt_q;
    if (!cfg_done) begin
      resolved = SRC_INT;
    end else begin
      case (sel_q)
        2'b00:   resolved = (prim_mode == PM_INTRC) ? SRC_INT : SRC_PRI;
        2'b01:   if (sec_osc_en) resolved = SRC_SEC;
        default: resolved = SRC_INT;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      req_d[i] = toh[i] && ((gseen & ~(NSRC'(1) << i)) == '0);
    end
  end

  always_ff @(posedge rc_clk) begin
    if (rst) begin
      sel_q       <= 2'b00;
      fsel_q      <= FSEL_W'(FSEL_RST);
      fsel_live_q <= FSEL_W'(FSEL_RST);
      tgt_q       <= SRC_INT;
      req_q       <= '0;
      busy_q      <= 1'b1;
      oe_q        <= 1'b0;
      for (int k = 0; k < GSYNC_STAGES; k++) gs_q[k] <= '0;
    end else begin
      gs_q[0] <= gate_async;
      for (int k = 1; k < GSYNC_STAGES; k++) gs_q[k] <= gs_q[k-1];
      if (sel_wr && !sel_drop) sel_q <= sel_wdata;
      if (fsel_wr)             fsel_q <= fsel_wdata;
      if (tgt_q != SRC_INT && !gseen[SRC_INT]) fsel_live_q <= fsel_q;
      if (settled)             tgt_q <= resolved;
      busy_q <= !(settled && (resolved == tgt_q));
      req_q  <= req_d;
      oe_q   <= cfg_done && (prim_mode == PM_RC);
    end
  end

  assign src_sel   = sel_q;
  assign freq_sel  = fsel_q;
  assign fsel_live = fsel_live_q;
  assign req       = req_q;
  assign busy      = busy_q;
  assign clko_oe   = oe_q;
  assign tgt       = tgt_q;
endmodule

// File: rtl/clksw_clkout.sv
`timescale 1ns/1ps
module clksw_clkout #(
  parameter int DIV_LOG2 = 2
) (
  input  logic sys_clk,
  input  logic rst,
  input  logic oe,
  output logic clko
);
  logic [DIV_LOG2-1:0] div_q;

  // sys_clk is stopped during reset, so the clear cannot wait for an edge
  always_ff @(posedge sys_clk or posedge rst) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign clko = oe & div_q[DIV_LOG2-1];
endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top
  import clksw_pkg::*;
#(
  parameter int FSEL_W       = 3,
  parameter int FSEL_RST     = 6,
  parameter int OFF_STAGES   = 2,
  parameter int ON_STAGES    = 3,
  parameter int RST_STAGES   = 2,
  parameter int GSYNC_STAGES = 2
) (
  input  logic              rst,
  input  logic              rc_clk,
  input  logic              pri_clk,
  input  logic              sec_clk,
  input  logic              cfg_done,
  input  logic [2:0]        prim_mode,
  input  logic              sec_osc_en,
  input  logic              sel_wr,
  input  logic [1:0]        sel_wdata,
  input  logic              fsel_wr,
  input  logic [FSEL_W-1:0] fsel_wdata,
  output logic              sys_clk,
  output logic              clko,
  output logic              clko_oe,
  output logic              busy,
  output logic [1:0]        src_sel,
  output logic [FSEL_W-1:0] freq_sel
);
  logic [NSRC-1:0]   src_clks, gate_w, gclk_w, req_w;
  logic [FSEL_W-1:0] fsel_live_w;
  logic              int_clk;
  src_e              tgt_w;

  clksw_ctrl #(
    .FSEL_W(FSEL_W), .FSEL_RST(FSEL_RST), .GSYNC_STAGES(GSYNC_STAGES)
  ) ctrl_i (
    .rc_clk(rc_clk), .rst(rst), .cfg_done(cfg_done), .prim_mode(prim_mode),
    .sec_osc_en(sec_osc_en), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .fsel_wr(fsel_wr), .fsel_wdata(fsel_wdata), .gate_async(gate_w),
    .src_sel(src_sel), .freq_sel(freq_sel), .fsel_live(fsel_live_w),
    .req(req_w), .busy(busy), .clko_oe(clko_oe), .tgt(tgt_w)
  );

  clksw_postscale #(.FSEL_W(FSEL_W)) post_i (
    .rc_clk(rc_clk), .rst(rst), .fsel(fsel_live_w), .int_clk(int_clk)
  );

  assign src_clks[SRC_PRI] = pri_clk;
  assign src_clks[SRC_SEC] = sec_clk;
  assign src_clks[SRC_INT] = int_clk;

  for (genvar i = 0; i < NSRC; i++) begin : g_branch
    clksw_branch #(
      .OFF_STAGES(OFF_STAGES), .ON_STAGES(ON_STAGES), .RST_STAGES(RST_STAGES)
    ) br_i (
      .src_clk(src_clks[i]), .rst(rst), .req(req_w[i]),
      .gate(gate_w[i]), .gclk(gclk_w[i])
    );
  end

  assign sys_clk = |gclk_w;

  clksw_clkout #(.DIV_LOG2(2)) cko_i (
    .sys_clk(sys_clk), .rst(rst), .oe(clko_oe), .clko(clko)
  );
endmodule

// File: rtl/clksw_chk.sv
`timescale 1ns/1ps
module clksw_chk #(
  parameter int FSEL_W = 3
) (
  input logic              rc_clk,
  input logic              rst,
  input logic              cfg_done,
  input logic              sec_osc_en,
  input logic              sel_wr,
  input logic [1:0]        sel_wdata,
  input logic [1:0]        src_sel,
  input logic [2:0]        gate,
  input logic [1:0]        tgt,
  input logic              busy,
  input logic [FSEL_W-1:0] fsel_live
);
  AST_GATES_EXCLUSIVE: assert property (@(posedge rc_clk) disable iff (rst)
    $onehot0(gate)); // R6

  AST_BOOT_INTERNAL: assert property (@(posedge rc_clk) disable iff (rst)
    (!cfg_done && !busy) |=> (tgt == 2'd2)); // R2

  AST_SEC_WRITE_DROPPED: assert property (@(posedge rc_clk) disable iff (rst)
    (sel_wr && sel_wdata == 2'b01 && !sec_osc_en) |=> $stable(src_sel)); // R4

  AST_IDLE_ONE_GATE: assert property (@(posedge rc_clk) disable iff (rst)
    !busy |-> $onehot(gate)); // R7

  AST_FSEL_HELD_OPEN: assert property (@(posedge rc_clk) disable iff (rst)
    gate[2] |-> $stable(fsel_live)); // R11
endmodule

bind clksw_top clksw_chk #(.FSEL_W(FSEL_W)) chk_i (
  .rc_clk(rc_clk), .rst(rst), .cfg_done(cfg_done), .sec_osc_en(sec_osc_en),
  .sel_wr(sel_wr), .sel_wdata(sel_wdata), .src_sel(src_sel), .gate(gate_w),
  .tgt(tgt_w), .busy(busy), .fsel_live(fsel_live_w)
);

// File: tb/clksw_top_tb_top.sv
`timescale 1ns/1ps
module clksw_top_tb_top;
  localparam real TRC = 8.0, TPRI = 20.0, TSEC = 60.0;

  logic rst = 1'b1, rc_clk = 1'b0, pri_clk = 1'b0, sec_clk = 1'b0;
  logic cfg_done = 1'b0, sec_osc_en = 1'b0, sel_wr = 1'b0, fsel_wr = 1'b0;
  logic [2:0] prim_mode = 3'd2, fsel_wdata = 3'd0;
  logic [1:0] sel_wdata = 2'd0;
  logic sys_clk, clko, clko_oe, busy;
  logic [1:0] src_sel;
  logic [2:0] freq_sel;

  always #4  rc_clk  = ~rc_clk;
  always #10 pri_clk = ~pri_clk;
  always #30 sec_clk = ~sec_clk;

  clksw_top dut_i (
    .rst(rst), .rc_clk(rc_clk), .pri_clk(pri_clk), .sec_clk(sec_clk),
    .cfg_done(cfg_done), .prim_mode(prim_mode), .sec_osc_en(sec_osc_en),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata), .fsel_wr(fsel_wr),
    .fsel_wdata(fsel_wdata), .sys_clk(sys_clk), .clko(clko),
    .clko_oe(clko_oe), .busy(busy), .src_sel(src_sel), .freq_sel(freq_sel)
  );

  int t_cmp = 0, t_bad = 0, c_cmp = 0, c_bad = 0;
  bit done = 1'b0;

  // output phase monitor
  real t_rise = 0.0, t_fall = 0.0, max_low = 0.0;
  bit  had_rise = 1'b0, had_fall = 1'b0;
  int  runts = 0, rises_in_rst = 0, arm_id = 0, seen_arm = 0;

  always @(posedge sys_clk) begin
    if (arm_id != seen_arm) begin max_low = 0.0; seen_arm = arm_id; end
    if (rst) rises_in_rst++;
    if (had_fall) begin
      if (($realtime - t_fall) < TRC/2.0 - 0.001) runts++;
      if (($realtime - t_fall) > max_low) max_low = $realtime - t_fall;
    end
    t_rise = $realtime; had_rise = 1'b1;
  end
  always @(negedge sys_clk) begin
    if (had_rise && ($realtime - t_rise) < TRC/2.0 - 0.001) runts++;
    t_fall = $realtime; had_fall = 1'b1;
  end

  // behavioural reference for the stored registers and the pin enable
  int m_sel = 0, m_fsel = 6, m_oe = 0;
  always @(posedge rc_clk) begin
    if (rst) begin m_sel = 0; m_fsel = 6; m_oe = 0; end
    else begin
      if (sel_wr && !(sel_wdata == 2'b01 && !sec_osc_en)) m_sel = int'(sel_wdata);
      if (fsel_wr) m_fsel = int'(fsel_wdata);
      m_oe = (cfg_done && prim_mode == 3'd2) ? 1 : 0;
    end
  end
  always @(negedge rc_clk) begin
    if (!rst && !done) begin
      c_cmp += 3;
      if (int'(src_sel) != m_sel) begin
        c_bad++; $display("FAIL R4 src_sel actual %0d expected %0d at %0t", src_sel, m_sel, $time);
      end
      if (int'(freq_sel) != m_fsel) begin
        c_bad++; $display("FAIL R11 freq_sel actual %0d expected %0d at %0t", freq_sel, m_fsel, $time);
      end
      if (int'(clko_oe) != m_oe) begin
        c_bad++; $display("FAIL R10 clko_oe actual %0d expected %0d at %0t", clko_oe, m_oe, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input real act, input real exp);
    t_cmp++;
    if (!ok) begin
      t_bad++;
      $display("FAIL %s %s actual %0.3f expected %0.3f", rq, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge rc_clk);
  endtask

  task automatic write_sel(input logic [1:0] v);
    @(negedge rc_clk); sel_wr = 1'b1; sel_wdata = v;
    @(negedge rc_clk); sel_wr = 1'b0;
  endtask

  task automatic write_fsel(input logic [2:0] v);
    @(negedge rc_clk); fsel_wr = 1'b1; fsel_wdata = v;
    @(negedge rc_clk); fsel_wr = 1'b0;
  endtask

  task automatic wait_idle(input string rq);
    int n = 0;
    while (busy && n < 2000) begin cyc(1); n++; end
    chk(!busy, rq, "busy did not clear", real'(busy), 0.0);
  endtask

  task automatic period(output real p);
    real t0;
    @(posedge sys_clk); t0 = $realtime;
    @(posedge sys_clk); p = $realtime - t0;
  endtask

  task automatic chk_period(input string rq, input real exp);
    real p;
    period(p);
    chk(p > exp - 0.01 && p < exp + 0.01, rq, "sys_clk period", p, exp);
  endtask

  task automatic quiet(input string rq, input int n);
    int hits = 0;
    for (int k = 0; k < n; k++) begin cyc(1); if (busy) hits++; end
    chk(hits == 0, rq, "busy cycles on non-switching write", real'(hits), 0.0);
  endtask

  task automatic switch_to(input logic [1:0] v, input real told, input real tnew, input string rq);
    real bound;
    arm_id++;
    write_sel(v);
    cyc(1);
    chk(busy == 1'b1, "R7", "busy after source change", real'(busy), 1.0);
    wait_idle("R7");
    chk_period(rq, tnew);
    bound = 2.0*told + 4.0*tnew + 6.0*TRC;
    chk(max_low <= bound, "R5", "longest low phase across switch", max_low, bound);
  endtask

  initial begin : wd
    #(200000 * 8);
    $display("FAIL R7 watchdog expired actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", t_cmp + c_cmp + 1, t_bad + c_bad + 1);
    $finish;
  end

  initial begin : main
    real p, t0;
    int lows;
    cyc(20);
    chk(rises_in_rst == 0, "R1", "sys_clk rises during reset", real'(rises_in_rst), 0.0);
    rst = 1'b0;
    cyc(1);
    chk(busy == 1'b1, "R1", "busy after reset", real'(busy), 1.0);
    chk(src_sel == 2'b00, "R1", "src_sel after reset", real'(src_sel), 0.0);
    chk(freq_sel == 3'b110, "R1", "freq_sel after reset", real'(freq_sel), 6.0);
    chk(clko_oe == 1'b0, "R1", "clko_oe after reset", real'(clko_oe), 0.0);
    wait_idle("R2");
    chk_period("R2", 2.0*TRC);
    write_sel(2'b01);
    cyc(4);
    chk_period("R2", 2.0*TRC);

    // configuration loaded in RC mode: 00 now means primary
    write_sel(2'b00);
    arm_id++;
    @(negedge rc_clk); cfg_done = 1'b1;
    cyc(2);
    chk(busy == 1'b1, "R7", "busy after cfg load", real'(busy), 1.0);
    wait_idle("R7");
    chk_period("R3", TPRI);
    chk(max_low <= 2.0*2.0*TRC + 4.0*TPRI + 6.0*TRC, "R5", "low phase internal to primary",
        max_low, 2.0*2.0*TRC + 4.0*TPRI + 6.0*TRC);
    @(posedge clko); t0 = $realtime; @(posedge clko); p = $realtime - t0;
    chk(p > 4.0*TPRI - 0.01 && p < 4.0*TPRI + 0.01, "R10", "clko period", p, 4.0*TPRI);

    // secondary request while disabled is dropped
    write_sel(2'b01);
    quiet("R4", 10);
    chk(src_sel == 2'b00, "R4", "src_sel after dropped write", real'(src_sel), 0.0);
    chk_period("R4", TPRI);

    // rewrite of the active source
    arm_id++;
    write_sel(2'b00);
    quiet("R9", 20);
    chk_period("R9", TPRI);
    chk(max_low <= TPRI/2.0 + 0.01, "R9", "low phase on same-source write", max_low, TPRI/2.0);

    // enable secondary, request it, then overwrite while busy
    sec_osc_en = 1'b1;
    write_sel(2'b01);
    write_sel(2'b10);
    chk(busy == 1'b1, "R8", "busy while second write pending", real'(busy), 1.0);
    wait_idle("R8");
    cyc(4);
    wait_idle("R8");
    chk(src_sel == 2'b10, "R8", "stored select after overwrite", real'(src_sel), 2.0);
    chk_period("R8", 2.0*TRC);

    switch_to(2'b01, 2.0*TRC, TSEC, "R3");
    switch_to(2'b11, TSEC, 2.0*TRC, "R3");

    // alias 10 while 11 active
    arm_id++;
    write_sel(2'b10);
    quiet("R3", 20);
    chk_period("R3", 2.0*TRC);

    // frequency write deferred while internal drives
    write_fsel(3'b111);
    cyc(10);
    chk_period("R11", 2.0*TRC);
    switch_to(2'b00, 2.0*TRC, TPRI, "R11");
    switch_to(2'b10, TPRI, TRC, "R11");

    // internal mode makes 00 an alias of the internal source
    @(negedge rc_clk); prim_mode = 3'd4;
    quiet("R3", 10);
    write_sel(2'b00);
    quiet("R9", 20);
    chk_period("R3", TRC);
    chk(clko_oe == 1'b0, "R10", "clko_oe in internal mode", real'(clko_oe), 0.0);

    // mode with released pin: 00 resolves to primary, pin stays low
    arm_id++;
    @(negedge rc_clk); prim_mode = 3'd3;
    cyc(2);
    chk(busy == 1'b1, "R7", "busy after mode change", real'(busy), 1.0);
    wait_idle("R7");
    chk_period("R3", TPRI);
    lows = 0;
    for (int k = 0; k < 50; k++) begin cyc(1); if (clko !== 1'b0) lows++; end
    chk(lows == 0 && clko_oe == 1'b0, "R10", "clko activity when released", real'(lows), 0.0);

    chk(runts == 0, "R6", "short output phases", real'(runts), 0.0);
    done = 1'b1;
    cyc(1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", t_cmp + c_cmp, t_bad + c_bad);
    $finish;
  end
endmodule